// File: doc/BRIEF.md
# Scalar Multiplier Register Front End

This block is the host-facing register bank of a 256-bit elliptic-curve scalar multiplication engine. A host on a simple synchronous word bus (chip select, write enable, word address, write data, registered read data) loads a 256-bit scalar as eight 32-bit words and starts an operation. It then polls a status word and reads back the affine X and Y coordinates of the result, each as eight 32-bit words. The block also presents two fixed identification words and a revision word.

On the engine side the block raises a one-cycle start request and waits for a one-cycle done pulse. While it runs, the engine reads scalar words by index and writes result words by index and buffer select. An operation starts only on a 0-to-1 change of the start bit in the control word, never on its level. The valid flag in the status word drops when an operation starts and rises when the engine reports completion.

The bus address is a word index: byte offset divided by four.

Top module: `pmul_regif`

## Requirements
- R1: Word addresses 0x00, 0x01 and 0x02 read 0x65636473, 0x61323536 and 0x302E3131. Host writes to them have no effect.
- R2: The control word is at word address 0x08. Only bit 1 (start bit) is stored. A read returns the stored start bit in bit 1 and 0 in all other bits.
- R3: `eng_start` is high for exactly one cycle. That cycle is the one after the clock edge where a host write changes the stored start bit from 0 to 1.
- R4: No start request is produced while the start bit stays 1, including when 1 is written again. Writing 0 and then 1 produces a new request.
- R5: The status word at word address 0x09 reads bit 0 (ready) as 1 and bits 31:2 as 0. Host writes to it have no effect.
- R6: Status bit 1 (valid) is cleared at the clock edge that ends the `eng_start` cycle. It is set at the clock edge that samples `eng_done` high.
- R7: Scalar word i (i = 0..7) sits at word address 0x20+i and holds scalar bits 32i+31:32i, so word 0 is least significant. The host can write it and read it back, and the engine reads it on `eng_k_word` for `eng_k_idx` = i.
- R8: The engine writes result word i into X (`eng_res_sel` = 0) or Y (`eng_res_sel` = 1). The host reads X word i at word address 0x28+i and Y word i at 0x30+i. Host writes to the result addresses have no effect.
- R9: Reads from any word address not listed in R1, R2, R5, R7 or R8 return 0.
- R10: `bus_rdata` is updated at the clock edge that samples a read (`bus_cs`=1, `bus_we`=0). After any edge without a read it is 0.
- R11: After reset the start bit, valid flag, scalar words and result words are 0, and `eng_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Host chip select |
| bus_we | input | 1 | Host write enable (1 write, 0 read) |
| bus_addr | input | 6 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_k_idx | input | 3 | Scalar word index requested by the engine |
| eng_k_word | output | 32 | Scalar word selected by eng_k_idx |
| eng_res_we | input | 1 | Result word write strobe |
| eng_res_sel | input | 1 | Result buffer select: 0 X, 1 Y |
| eng_res_idx | input | 3 | Result word index |
| eng_res_word | input | 32 | Result word data |

## Verification
A wrong edge-detector state shows as a missing start request on a fresh 0-to-1 write, or as an extra one on a repeated write of 1. Either way it appears on `eng_start` one cycle after the write edge, and the stub engine then leaves the result words unchanged or overwrites them. A stuck or wrongly ordered valid flag is seen on the first status read issued after the start cycle. A scalar or result buffer with swapped or shifted words appears in the readback of the first operation, because each result word is a distinct function of the scalar word at the same index.

// File: rtl/pmul_regs_pkg.sv
package pmul_regs_pkg;
  localparam int unsigned DW = 32;

  // identification constants
  localparam logic [DW-1:0] ID_WORD0 = 32'h6563_6473;
  localparam logic [DW-1:0] ID_WORD1 = 32'h6132_3536;
  localparam logic [DW-1:0] REV_WORD = 32'h302E_3131;

  // word addresses (byte offset / 4)
  localparam int unsigned WA_ID0    = 0;
  localparam int unsigned WA_ID1    = 1;
  localparam int unsigned WA_REV    = 2;
  localparam int unsigned WA_CTRL   = 8;
  localparam int unsigned WA_STAT   = 9;
  localparam int unsigned WA_SCALAR = 32;
  localparam int unsigned WA_RES_X  = 40;
  localparam int unsigned WA_RES_Y  = 48;

  localparam int unsigned GO_BIT  = 1;
  localparam int unsigned RDY_BIT = 0;
  localparam int unsigned VLD_BIT = 1;

  function automatic logic [DW-1:0] ctrl_word(input logic go);
    logic [DW-1:0] w;
    w = '0;
    w[GO_BIT] = go;
    return w;
  endfunction

  function automatic logic [DW-1:0] stat_word(input logic vld);
    logic [DW-1:0] w;
    w = '0;
    w[RDY_BIT] = 1'b1;
    w[VLD_BIT] = vld;
    return w;
  endfunction
endpackage

// File: rtl/pmul_go_edge.sv
module pmul_go_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign pulse = level & ~level_d;
endmodule

// File: rtl/pmul_word_buf.sv
module pmul_word_buf #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [WORDS*DW-1:0] words
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < int'(WORDS); g++) begin : g_flat
    assign words[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/pmul_regif.sv
module pmul_regif
  import pmul_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORDS  = 8,
  parameter int unsigned IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic [IDX_W-1:0]  eng_k_idx,
  output logic [DW-1:0]     eng_k_word,
  input  logic              eng_res_we,
  input  logic              eng_res_sel,
  input  logic [IDX_W-1:0]  eng_res_idx,
  input  logic [DW-1:0]     eng_res_word
);
  localparam int unsigned FLAT_W = WORDS * DW;

  function automatic logic in_region(input logic [ADDR_W-1:0] a, input int unsigned base);
    logic [31:0] wide;
    wide = {{(32-ADDR_W){1'b0}}, a};
    return (wide >> IDX_W) == (base >> IDX_W);
  endfunction

  function automatic logic at_addr(input logic [ADDR_W-1:0] a, input int unsigned wa);
    return {{(32-ADDR_W){1'b0}}, a} == wa;
  endfunction

  // named events for the checker
  logic rd_req, wr_req;
  logic ctrl_q, valid_q;
  logic hit_k, hit_x, hit_y;
  logic [IDX_W-1:0] bus_idx;
  logic [DW-1:0] rd_next;
  logic [FLAT_W-1:0] k_flat;
  logic [FLAT_W-1:0] res_flat [2];

  assign rd_req  = bus_cs & ~bus_we;
  assign wr_req  = bus_cs & bus_we;
  assign bus_idx = bus_addr[IDX_W-1:0];
  assign hit_k   = in_region(bus_addr, WA_SCALAR);
  assign hit_x   = in_region(bus_addr, WA_RES_X);
  assign hit_y   = in_region(bus_addr, WA_RES_Y);

  // control: only the start bit is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b0;
    else if (wr_req && at_addr(bus_addr, WA_CTRL)) ctrl_q <= bus_wdata[GO_BIT];
  end

  pmul_go_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ctrl_q),
    .pulse (eng_start)
  );

  // valid: start has priority over a coincident done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= 1'b0;
    else if (eng_start) valid_q <= 1'b0;
    else if (eng_done)  valid_q <= 1'b1;
  end

  pmul_word_buf #(.WORDS(WORDS), .DW(DW)) u_scalar (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_req & hit_k),
    .wr_idx  (bus_idx),
    .wr_data (bus_wdata),
    .words   (k_flat)
  );

  for (genvar g = 0; g < 2; g++) begin : g_res
    pmul_word_buf #(.WORDS(WORDS), .DW(DW)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (eng_res_we && (eng_res_sel == g[0])),
      .wr_idx  (eng_res_idx),
      .wr_data (eng_res_word),
      .words   (res_flat[g])
    );
  end

  assign eng_k_word = k_flat[eng_k_idx*DW +: DW];

  always_comb begin
    rd_next = '0;
    if      (at_addr(bus_addr, WA_ID0))  rd_next = ID_WORD0;
    else if (at_addr(bus_addr, WA_ID1))  rd_next = ID_WORD1;
    else if (at_addr(bus_addr, WA_REV))  rd_next = REV_WORD;
    else if (at_addr(bus_addr, WA_CTRL)) rd_next = ctrl_word(ctrl_q);
    else if (at_addr(bus_addr, WA_STAT)) rd_next = stat_word(valid_q);
    else if (hit_k) rd_next = k_flat[bus_idx*DW +: DW];
    else if (hit_x) rd_next = res_flat[0][bus_idx*DW +: DW];
    else if (hit_y) rd_next = res_flat[1][bus_idx*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_req ? rd_next : '0;
  end
endmodule

// File: rtl/pmul_regif_chk.sv
module pmul_regif_chk
  import pmul_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic              eng_start,
  input logic              eng_done,
  input logic              ctrl_q,
  input logic              valid_q
);
  logic rd;
  assign rd = bus_cs & ~bus_we;

  // R3: request lasts one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R3: request only follows a 0-to-1 change of the stored bit
  a_r3_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (ctrl_q && !$past(ctrl_q)));

  // R4: a held start bit never requests
  a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q && $past(ctrl_q)) |-> !eng_start);

  // R6: valid drops after the start cycle
  a_r6_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !valid_q);

  // R6: done raises valid
  a_r6_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_start) |=> valid_q);

  // R5: status readback shape
  a_r5_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == ADDR_W'(WA_STAT)) |=> (bus_rdata[RDY_BIT] && bus_rdata[DW-1:2] == '0));

  // R1: first identification word
  a_r1_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == ADDR_W'(WA_ID0)) |=> (bus_rdata == ID_WORD0));

  // R10: no read, zero data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (bus_rdata == '0));
endmodule

bind pmul_regif pmul_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .ctrl_q    (ctrl_q),
  .valid_q   (valid_q)
);

// File: tb/test_pmul_regif.sv
module test_pmul_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start;
  logic        eng_done = 1'b0;
  logic [2:0]  eng_k_idx = '0;
  logic [31:0] eng_k_word;
  logic        eng_res_we = 1'b0, eng_res_sel = 1'b0;
  logic [2:0]  eng_res_idx = '0;
  logic [31:0] eng_res_word = '0;

  int n_checks = 0, n_fail = 0, n_starts = 0;

  always #10 clk = ~clk;

  pmul_regif i_pmul_regif (.*);

  // stub engine: X[i] = k[i] ^ 5A5A5A5A, Y[i] = ~k[i]
  localparam logic [31:0] XMASK = 32'h5A5A_5A5A;
  int  st_cnt = 0;
  bit  st_busy = 0;
  always @(negedge clk) begin
    eng_res_we = 1'b0;
    eng_done   = 1'b0;
    if (eng_start && !st_busy) begin
      st_busy = 1; st_cnt = 0; eng_k_idx = 3'd0;
    end else if (st_busy) begin
      st_cnt++;
      if (st_cnt <= 16) begin
        eng_res_we   = 1'b1;
        eng_res_sel  = (st_cnt - 1) >= 8;
        eng_res_idx  = 3'((st_cnt - 1) % 8);
        eng_res_word = eng_res_sel ? ~eng_k_word : (eng_k_word ^ XMASK);
        eng_k_idx    = 3'(st_cnt % 8);
      end else if (st_cnt == 17) begin
        eng_done = 1'b1;
      end else begin
        st_busy = 0;
      end
    end
  end

  always @(posedge clk) if (rst_n && eng_start) n_starts++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_cs = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R11 start low", {31'b0, eng_start}, 32'd0);
    bus_read(6'h08, d); check("R11 ctrl zero", d, 32'd0);
    bus_read(6'h09, d); check("R11 valid zero", d, 32'd1);
    bus_read(6'h20, d); check("R11 scalar zero", d, 32'd0);
    bus_read(6'h2F, d); check("R11 X zero", d, 32'd0);
    bus_read(6'h37, d); check("R11 Y zero", d, 32'd0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    bus_write(6'h00, 32'h0); bus_write(6'h02, 32'hFFFF_FFFF);
    bus_read(6'h00, d); check("R1 id0", d, 32'h6563_6473);
    bus_read(6'h01, d); check("R1 id1", d, 32'h6132_3536);
    bus_read(6'h02, d); check("R1 rev", d, 32'h302E_3131);
    bus_write(6'h09, 32'hFFFF_FFFF);
    bus_read(6'h09, d); check("R5 status write ignored", d, 32'd1);
  endtask

  task automatic t_edge_timing();
    logic [31:0] d;
    int s0;
    bus_write(6'h08, 32'h0);
    s0 = n_starts;
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_addr = 6'h08; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
    check("R3 start in cycle after write", {31'b0, eng_start}, 32'd1);
    @(negedge clk);
    check("R3 start one cycle", {31'b0, eng_start}, 32'd0);
    bus_read(6'h09, d); check("R6 valid cleared after start", d, 32'd1);
    bus_read(6'h08, d); check("R2 only bit1 stored", d, 32'd2);
    check("R3 one request", n_starts - s0, 32'd1);
    wait (!st_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    int s0;
    s0 = n_starts;
    bus_write(6'h08, 32'h2); bus_write(6'h08, 32'h2);
    repeat (3) @(negedge clk);
    check("R4 held bit no request", n_starts - s0, 32'd0);
    bus_write(6'h08, 32'h1);
    bus_read(6'h08, d); check("R2 bit0 ignored", d, 32'd0);
    check("R4 clear no request", n_starts - s0, 32'd0);
    bus_write(6'h08, 32'h2);
    repeat (2) @(negedge clk);
    check("R4 rewrite requests", n_starts - s0, 32'd1);
    wait (!st_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_run(input logic [31:0] seed);
    logic [31:0] k [8];
    logic [31:0] d;
    int guard;
    for (int i = 0; i < 8; i++) begin
      k[i] = seed * (i + 3) + 32'h0101_0000 * i;
      bus_write(6'(32 + i), k[i]);
    end
    for (int i = 0; i < 8; i++) begin
      bus_read(6'(32 + i), d); check("R7 scalar readback", d, k[i]);
    end
    bus_write(6'h08, 32'h0);
    bus_write(6'h08, 32'h2);
    bus_read(6'h09, d); check("R6 valid low while busy", d, 32'd1);
    guard = 0;
    do begin bus_read(6'h09, d); guard++; end while (d[1] == 1'b0 && guard < 100);
    check("R6 valid set on done", d, 32'd3);
    for (int i = 0; i < 8; i++) begin
      bus_read(6'(40 + i), d); check("R8 X word order", d, k[i] ^ XMASK);
      bus_read(6'(48 + i), d); check("R8 Y word order", d, ~k[i]);
    end
    bus_write(6'h28, 32'hDEAD_BEEF);
    bus_read(6'h28, d); check("R8 result write ignored", d, k[0] ^ XMASK);
    bus_write(6'h08, 32'h2);
    bus_read(6'h09, d); check("R4 R6 no restart keeps valid", d, 32'd3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(6'h03, d); check("R9 addr 03", d, 32'd0);
    bus_read(6'h0A, d); check("R9 addr 0A", d, 32'd0);
    bus_read(6'h38, d); check("R9 addr 38", d, 32'd0);
    bus_read(6'h3F, d); check("R9 addr 3F", d, 32'd0);
  endtask

  task automatic t_idle();
    bus_read(6'h00, d_dummy);
    @(negedge clk);
    check("R10 zero after idle edge", bus_rdata, 32'd0);
  endtask
  logic [31:0] d_dummy;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_edge_timing();
    t_hold();
    t_run(32'h1357_9BDF);
    t_run(32'hF00D_0042);
    t_unmapped();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule